// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block maps a virtual address, issued for an instruction fetch, a data load or a data store, to a physical address. It uses a one-level page table that lives in physical memory. A request carries the virtual address and an access type. The block splits the address into a virtual page number and a page offset. It adds the page number to a per-process table base register, then reads that one-word entry over a simple read port.

The entry supplies a valid bit, a two-bit rights field and a physical page number. An invalid entry ends the request with a page fault. A valid entry whose rights do not allow the access ends it with a protection fault. Otherwise the physical page number is joined to the unchanged offset. Every request finishes with a single done pulse that carries the address and both fault flags.

Top module: `ptw_top`

## Requirements
- R1: After reset, req_ready_o is 1, and busy_o, done_o, mem_req_o, pa_o and both fault flags are 0.
- R2: The cycle after a request is accepted (req_valid_i and req_ready_o both high at a clock edge), mem_req_o is high for exactly one cycle, with mem_addr_o = table base + VPN, where VPN = req_va_i[14:10] under the default geometry.
- R3: The entry word is laid out as bit 7 = valid, bits 6:5 = rights, bits 2:0 = physical page number. On an allowed access to a valid page, pa_o = {PPN, req_va_i[9:0]} and both fault flags are 0.
- R4: When the entry's valid bit is 0, page_fault_o is 1, prot_fault_o is 0 and pa_o is 0, whatever the rights field holds.
- R5: Rights 00 = read-only, 01 = read/write, 10 = execute-only, 11 = read/write/execute. Access type 00 = read, 01 = write, 10 = fetch. A valid entry that does not allow the access gives prot_fault_o = 1, page_fault_o = 0 and pa_o = 0.
- R6: done_o is high in the cycle after mem_rvalid_i is seen, which is three cycles after acceptance when memory answers in one cycle. It stays high for one cycle only.
- R7: busy_o is high and req_ready_o is low from the cycle after acceptance until done_o. A request presented during that time is ignored and starts no memory read.
- R8: A base register write while idle applies to the next request. A write while busy is dropped, so the next request still uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptb_we_i | input | 1 | Table base write strobe |
| ptb_wdata_i | input | 10 | New table base (word address) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_va_i | input | 15 | Virtual address |
| req_acc_i | input | 2 | Access type: 00 read, 01 write, 10 fetch |
| busy_o | output | 1 | Translation in progress |
| mem_req_o | output | 1 | Entry read strobe |
| mem_addr_o | output | 10 | Entry word address |
| mem_rvalid_i | input | 1 | Entry read data valid |
| mem_rdata_i | input | 8 | Entry word |
| done_o | output | 1 | One-cycle result pulse |
| pa_o | output | 13 | Physical address, 0 on fault |
| page_fault_o | output | 1 | Entry invalid |
| prot_fault_o | output | 1 | Access not allowed by rights |

## Verification
The acceptance edge is the reference point for every check. The entry read strobe and its address are due in the first cycle after that edge. The memory model answers one cycle later, and the result pulse with its address and flags comes in the third cycle. The bench samples each of these on falling edges at exactly those offsets and checks that done_o has dropped one cycle later. Pokes on the base and request inputs land in the cycle the strobe is out, and their lack of effect shows in the next translation's entry address and in the absence of a memory read after done.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    RT_RO  = 2'b00,
    RT_RW  = 2'b01,
    RT_XO  = 2'b10,
    RT_RWX = 2'b11
  } rights_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10
  } state_e;

  function automatic logic access_ok(rights_e r, acc_e a);
    logic ok;
    unique case (r)
      RT_RO:   ok = (a == ACC_READ);
      RT_RW:   ok = (a == ACC_READ) || (a == ACC_WRITE);
      RT_XO:   ok = (a == ACC_EXEC);
      default: ok = (a != ACC_RSVD);
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          busy_i,
  output logic [AW-1:0] base_o
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              base_q <= '0;
    else if (we_i && !busy_i) base_q <= wdata_i;
  end

  assign base_o = base_q;

  AST_BASE_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(base_q)); // R8
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int unsigned PTE_W = 8,
  parameter int unsigned PPN_W = 3
) (
  input  logic [PTE_W-1:0] pte_i,
  input  acc_e             acc_i,
  output logic [PPN_W-1:0] ppn_o,
  output logic             page_fault_o,
  output logic             prot_fault_o
);
  localparam int unsigned VLD_BIT = PTE_W - 1;
  localparam int unsigned RT_MSB  = PTE_W - 2;

  logic    vld;
  rights_e rights;

  assign vld          = pte_i[VLD_BIT];
  assign rights       = rights_e'(pte_i[RT_MSB -: 2]);
  assign ppn_o        = pte_i[PPN_W-1:0];
  // invalid wins over rights
  assign page_fault_o = !vld;
  assign prot_fault_o = vld && !access_ok(rights, acc_i);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W   = 15,
  parameter int unsigned OFF_W  = 10,
  parameter int unsigned VPN_W  = 5,
  parameter int unsigned PPN_W  = 3,
  parameter int unsigned MEM_AW = 10,
  parameter int unsigned PA_W   = PPN_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [1:0]        req_acc_i,
  output logic              req_ready_o,
  output logic              busy_o,
  input  logic [MEM_AW-1:0] base_i,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  output acc_e              acc_o,
  input  logic [PPN_W-1:0]  ppn_i,
  input  logic              pf_i,
  input  logic              prot_i,
  output logic              done_o,
  output logic [PA_W-1:0]   pa_o,
  output logic              pf_o,
  output logic              prot_o
);
  state_e            state_q;
  logic [VA_W-1:0]   va_q;
  acc_e              acc_q;
  logic              done_q, pf_q, prot_q;
  logic [PA_W-1:0]   pa_q;
  logic [VPN_W-1:0]  vpn;

  assign vpn = va_q[OFF_W +: VPN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= ACC_READ;
      done_q  <= 1'b0;
      pf_q    <= 1'b0;
      prot_q  <= 1'b0;
      pa_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          acc_q   <= acc_e'(req_acc_i);
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          pf_q    <= pf_i;
          prot_q  <= prot_i;
          pa_q    <= (pf_i || prot_i) ? '0 : {ppn_i, va_q[OFF_W-1:0]};
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_ISSUE);
  assign mem_addr_o  = base_i + {{(MEM_AW-VPN_W){1'b0}}, vpn};
  assign acc_o       = acc_q;
  assign done_o      = done_q;
  assign pa_o        = pa_q;
  assign pf_o        = pf_q;
  assign prot_o      = prot_q;

  AST_ACCEPT_ISSUES_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> mem_req_o); // R2
  AST_READ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_req_o && mem_rvalid_i) |=> done_o); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o); // R7
  AST_FAULT_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (pf_o || prot_o)) |-> (pa_o == '0)); // R4
  AST_ONE_FAULT_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(pf_o && prot_o)); // R5
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pf_o && !prot_o) |-> (pa_o[OFF_W-1:0] == va_q[OFF_W-1:0])); // R3
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 1024,
  parameter int unsigned VPAGES     = 32,
  parameter int unsigned PPAGES     = 8,
  parameter int unsigned MEM_AW     = 10,
  parameter int unsigned PTE_W      = 8,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
  localparam int unsigned VPN_W     = $clog2(VPAGES),
  localparam int unsigned PPN_W     = $clog2(PPAGES),
  localparam int unsigned VA_W      = VPN_W + OFF_W,
  localparam int unsigned PA_W      = PPN_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptb_we_i,
  input  logic [MEM_AW-1:0] ptb_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [1:0]        req_acc_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  output logic              done_o,
  output logic [PA_W-1:0]   pa_o,
  output logic              page_fault_o,
  output logic              prot_fault_o
);
  logic [MEM_AW-1:0] base;
  acc_e              acc;
  logic [PPN_W-1:0]  ppn;
  logic              pf, prot;

  ptw_base_reg #(.AW(MEM_AW)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ptb_we_i),
    .wdata_i (ptb_wdata_i),
    .busy_i  (busy_o),
    .base_o  (base)
  );

  ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_dec (
    .pte_i        (mem_rdata_i),
    .acc_i        (acc),
    .ppn_o        (ppn),
    .page_fault_o (pf),
    .prot_fault_o (prot)
  );

  ptw_ctrl #(
    .VA_W(VA_W), .OFF_W(OFF_W), .VPN_W(VPN_W), .PPN_W(PPN_W),
    .MEM_AW(MEM_AW), .PA_W(PA_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_va_i     (req_va_i),
    .req_acc_i    (req_acc_i),
    .req_ready_o  (req_ready_o),
    .busy_o       (busy_o),
    .base_i       (base),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .acc_o        (acc),
    .ppn_i        (ppn),
    .pf_i         (pf),
    .prot_i       (prot),
    .done_o       (done_o),
    .pa_o         (pa_o),
    .pf_o         (page_fault_o),
    .prot_o       (prot_fault_o)
  );
endmodule

// File: tb/ptw_top_tb_top.sv
module ptw_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptb_we = 1'b0;
  logic [9:0]  ptb_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [14:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        busy, mem_req, mem_rvalid, done, pf, prot;
  logic [9:0]  mem_addr;
  logic [7:0]  mem_rdata;
  logic [12:0] pa;
  logic [7:0]  mem [0:1023];
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ptb_we_i(ptb_we), .ptb_wdata_i(ptb_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_acc_i(req_acc), .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .done_o(done), .pa_o(pa),
    .page_fault_o(pf), .prot_fault_o(prot)
  );

  // one-cycle read memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_req;
      mem_rdata  <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_pte(input int base, input int vpn, input bit v,
                         input logic [1:0] rt, input logic [2:0] ppn);
    mem[(base + vpn) % 1024] = {v, rt, 2'b00, ppn};
  endtask

  task automatic set_base(input logic [9:0] b);
    @(negedge clk);
    ptb_we = 1'b1; ptb_wdata = b;
    @(negedge clk);
    ptb_we = 1'b0;
  endtask

  // acceptance edge -> ISSUE (+1) -> WAIT (+2) -> done (+3)
  task automatic xlate(input string tag, input logic [14:0] va, input logic [1:0] acc,
                       input int exp_addr, input bit exp_pf, input bit exp_prot,
                       input int exp_pa, input bit poke_base, input bit poke_req);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_req == 1'b1, {tag, " R2 mem_req"}, mem_req, 1);
    chk(mem_addr == 10'(exp_addr), {tag, " R2 mem_addr"}, mem_addr, exp_addr);
    chk(busy && !req_ready, {tag, " R7 busy/ready"}, {busy, req_ready}, 2);
    if (poke_base) begin ptb_we = 1'b1; ptb_wdata = 10'h3F0; end
    if (poke_req) begin req_valid = 1'b1; req_va = 15'h7FFF; req_acc = 2'b00; end
    @(negedge clk);
    ptb_we = 1'b0; req_valid = 1'b0;
    chk(!done && !mem_req, {tag, " R6 no early done"}, {done, mem_req}, 0);
    @(negedge clk);
    chk(done == 1'b1, {tag, " R6 done"}, done, 1);
    chk(pf == exp_pf, {tag, " R4 page_fault"}, pf, exp_pf);
    chk(prot == exp_prot, {tag, " R5 prot_fault"}, prot, exp_prot);
    chk(pa == 13'(exp_pa), {tag, " R3 pa"}, pa, exp_pa);
    @(negedge clk);
    chk(!done && req_ready && !busy, {tag, " R6 pulse end"}, {done, req_ready, busy}, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    set_pte(10'h040, 1, 1'b1, 2'b01, 3'd5);   // RW
    set_pte(10'h040, 2, 1'b1, 2'b00, 3'd3);   // RO
    set_pte(10'h040, 3, 1'b1, 2'b10, 3'd6);   // XO
    set_pte(10'h040, 4, 1'b1, 2'b11, 3'd7);   // RWX
    set_pte(10'h040, 5, 1'b0, 2'b11, 3'd2);   // invalid
    set_pte(10'h040, 31, 1'b1, 2'b00, 3'd1);  // top VPN, RO
    set_pte(10'h100, 1, 1'b1, 2'b01, 3'd2);   // second table

    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !done && !mem_req && pa == 0 && !pf && !prot,
        "R1 reset state", {req_ready, busy, done, mem_req, pf, prot}, 32);
    rst_n = 1'b1;

    set_base(10'h040);
    xlate("R3 read RW",       {5'd1, 10'h2A5}, 2'b00, 'h041, 0, 0, {3'd5, 10'h2A5}, 0, 0);
    xlate("R5 write RW",      {5'd1, 10'h001}, 2'b01, 'h041, 0, 0, {3'd5, 10'h001}, 0, 0);
    xlate("R5 write RO",      {5'd2, 10'h100}, 2'b01, 'h042, 0, 1, 0, 0, 0);
    xlate("R5 read RO",       {5'd2, 10'h3FF}, 2'b00, 'h042, 0, 0, {3'd3, 10'h3FF}, 0, 0);
    xlate("R5 fetch XO",      {5'd3, 10'h010}, 2'b10, 'h043, 0, 0, {3'd6, 10'h010}, 0, 0);
    xlate("R5 read XO",       {5'd3, 10'h010}, 2'b00, 'h043, 0, 1, 0, 0, 0);
    xlate("R5 fetch RW",      {5'd1, 10'h000}, 2'b10, 'h041, 0, 1, 0, 0, 0);
    xlate("R5 write RWX",     {5'd4, 10'h155}, 2'b01, 'h044, 0, 0, {3'd7, 10'h155}, 0, 0);
    xlate("R4 invalid",       {5'd5, 10'h155}, 2'b10, 'h045, 1, 0, 0, 0, 0);
    xlate("R4 zero entry",    {5'd9, 10'h001}, 2'b00, 'h049, 1, 0, 0, 0, 0);
    xlate("R3 top vpn",       {5'd31, 10'h3FF}, 2'b00, 'h05F, 0, 0, {3'd1, 10'h3FF}, 0, 0);

    // R8 write during busy dropped
    xlate("R8 poke base",     {5'd1, 10'h077}, 2'b00, 'h041, 0, 0, {3'd5, 10'h077}, 1, 0);
    xlate("R8 old base kept", {5'd1, 10'h078}, 2'b00, 'h041, 0, 0, {3'd5, 10'h078}, 0, 0);
    // R8 idle write applies
    set_base(10'h100);
    xlate("R8 new base",      {5'd1, 10'h078}, 2'b00, 'h101, 0, 0, {3'd2, 10'h078}, 0, 0);

    // R7 request during busy ignored
    xlate("R7 poke req",      {5'd1, 10'h00F}, 2'b00, 'h101, 0, 0, {3'd2, 10'h00F}, 0, 1);
    begin
      int extra = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (mem_req || done) extra++;
      end
      chk(extra == 0, "R7 ignored request", extra, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule